// File: doc/BRIEF.md
# Timed Switching-Pattern Player

This block plays back one period of a precomputed switching pattern for the four gate signals of an H-bridge. A host loads a small local table of events through a byte-wide write port. Each event is a 16-bit hold count plus an 8-bit pattern byte. The host also writes an event count and then pulses a start input. The block then drives the low four pattern bits onto its gate pins. It keeps each pattern for the programmed number of clock ticks, moves to the next event, and after the final event returns to event 0 without a gap.

A stop request is looked at only on the edge where the period wraps. When the request is low the period repeats. When it is high the block returns to idle, and in idle every pin is driven low. On every wrap a trigger pin pulses so that an oscilloscope can lock onto the period.

The controller is a three-state machine:
- **IDLE**: the outputs are quiet. A start with a nonzero count goes to LAUNCH and captures entry 0 into the prefetch register.
- **LAUNCH**: lasts one cycle, drives entry 0 and goes to PLAY.
- **PLAY**: counts the hold down. When the hold ends it loads the prefetched entry and stays in PLAY. The one exception is the wrap edge with the stop request set, which goes to IDLE.

Top module: `seq_player`

## Requirements
- R1: Table bytes are written at byte address 5*e+o, where e is the entry and o the offset. Offset 0 is the hold count's low byte, offset 1 its high byte and offset 4 the pattern byte. Writes to offsets 2 and 3, and writes to addresses at or above 5*ENTRIES, change nothing.
- R2: The count written on the length port is saturated to ENTRIES. A start while the count is zero is ignored: busy stays low and every pin stays 0.
- R3: A start sampled while idle with a nonzero count raises busy after that edge, with all pins still 0. Entry 0 reaches the pins after the next edge. Without a start, an idle block stays idle.
- R4: Each event drives pattern bits 3:0 onto pins_out[3:0] for exactly its hold count in cycles, and a hold count of 0 counts as 1. Bit 0 is leg A high, bit 1 is leg A low, bit 2 is leg B high and bit 3 is leg B low. Pattern bits 7:4 never reach the pins.
- R5: After the last entry of the saved count, playback goes on with entry 0 in the very next cycle, with no idle cycle in between.
- R6: pins_out[4] is high for exactly the first cycle of entry 0 after each wrap. It stays low during the first period after a start.
- R7: stop_req is sampled only on the wrap edge. If it is high there, the block goes idle after that edge. A high stop_req on any other edge has no effect.
- R8: While idle, pins_out is all zero and busy is low. A start while busy is ignored.
- R9: After reset the block is idle, with pins_out = 0 and busy = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table byte write strobe |
| tbl_addr | input | ADDR_W | Table byte address (5-byte entry stride) |
| tbl_wdata | input | 8 | Table byte data |
| len_we | input | 1 | Event count write strobe |
| len_wdata | input | LEN_W | Event count (saturated to ENTRIES) |
| run_start | input | 1 | Start playback pulse |
| stop_req | input | 1 | Stop request, sampled at period wrap |
| pins_out | output | 5 | [3:0] gate pattern, [4] wrap trigger |
| busy | output | 1 | High from start until stop |

## Verification
The checker assumes that the host does not write the table or the count while busy is high. Under that assumption the pins depend only on the saved entries. The bench keeps to this by doing every table and count write before a start, and starting again only after it has seen the block idle. The bench holds stop_req high throughout the final period it plays. In earlier periods it raises stop_req only on a non-wrap edge, so the only way the block can leave PLAY is through the wrap edge that the checker relates to stop_req.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_PLAY   = 2'd2
    } seq_state_t;

    localparam int ENTRY_STRIDE = 5;
    localparam int OFF_HOLD_LO  = 0;
    localparam int OFF_HOLD_HI  = 1;
    localparam int OFF_PATTERN  = 4;
    localparam int HOLD_W       = 16;
    localparam int PAT_W        = 8;
    localparam int GATE_W       = 4;

endpackage

// File: rtl/seq_table.sv
module seq_table
    import seq_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = $clog2(ENTRIES * ENTRY_STRIDE + 1),
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HOLD_W-1:0] rd_hold,
    output logic [PAT_W-1:0]  rd_pat
);

    localparam int TABLE_BYTES = ENTRIES * ENTRY_STRIDE;

    logic [ADDR_W-1:0] wr_entry;
    logic [ADDR_W-1:0] wr_off;
    logic              wr_hit;

    logic [HOLD_W-1:0] hold_arr [ENTRIES];
    logic [PAT_W-1:0]  pat_arr  [ENTRIES];

    assign wr_entry = wr_addr / ADDR_W'(ENTRY_STRIDE);
    assign wr_off   = wr_addr % ADDR_W'(ENTRY_STRIDE);
    assign wr_hit   = wr_en && (wr_addr < ADDR_W'(TABLE_BYTES));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic [HOLD_W-1:0] hold_r;
        logic [PAT_W-1:0]  pat_r;
        logic              sel;

        assign sel = wr_hit && (wr_entry == ADDR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_r <= '0;
                pat_r  <= '0;
            end else if (sel) begin
                unique case (wr_off)
                    ADDR_W'(OFF_HOLD_LO): hold_r[7:0]  <= wr_data;
                    ADDR_W'(OFF_HOLD_HI): hold_r[15:8] <= wr_data;
                    ADDR_W'(OFF_PATTERN): pat_r        <= wr_data;
                    default: ;
                endcase
            end
        end

        assign hold_arr[g] = hold_r;
        assign pat_arr[g]  = pat_r;
    end

    assign rd_hold = hold_arr[rd_idx];
    assign rd_pat  = pat_arr[rd_idx];

endmodule

// File: rtl/seq_len_reg.sv
module seq_len_reg #(
    parameter int ENTRIES = 16,
    parameter int LEN_W   = 8,
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_wdata,
    output logic [CNT_W-1:0] len_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_we) begin
            if (len_wdata > LEN_W'(ENTRIES)) begin
                len_q <= CNT_W'(ENTRIES);
            end else begin
                len_q <= CNT_W'(len_wdata);
            end
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_start,
    input  logic              stop_req,
    input  logic [CNT_W-1:0]  len_cfg,
    input  logic [HOLD_W-1:0] rd_hold,
    input  logic [PAT_W-1:0]  rd_pat,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [GATE_W-1:0] gate_out,
    output logic              trig_out,
    output logic              busy
);

    seq_state_t state_q, state_d;

    logic [IDX_W-1:0]  last_idx_q;
    logic [IDX_W-1:0]  nxt_idx_q;
    logic [IDX_W-1:0]  succ_idx;
    logic [HOLD_W-1:0] nxt_hold_q;
    logic [PAT_W-1:0]  nxt_pat_q;
    logic [HOLD_W-1:0] hold_q;
    logic [GATE_W-1:0] gate_q;
    logic              trig_q;

    logic start_ok;
    logic hold_end;
    logic wrap_due;
    logic exit_now;
    logic load_evt;

    assign succ_idx = (nxt_idx_q == last_idx_q) ? '0 : nxt_idx_q + 1'b1;
    assign rd_idx   = (state_q == ST_IDLE) ? '0 : succ_idx;
    assign start_ok = run_start && (len_cfg != '0);
    assign hold_end = (hold_q == HOLD_W'(1));
    assign wrap_due = hold_end && (nxt_idx_q == '0);
    assign exit_now = (state_q == ST_PLAY) && wrap_due && stop_req;
    assign load_evt = (state_q == ST_LAUNCH) ||
                      ((state_q == ST_PLAY) && hold_end && !exit_now);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_PLAY;
            ST_PLAY:   if (exit_now) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // prefetch and playback datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_idx_q <= '0;
            nxt_idx_q  <= '0;
            nxt_hold_q <= '0;
            nxt_pat_q  <= '0;
            hold_q     <= '0;
            gate_q     <= '0;
            trig_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    gate_q <= '0;
                    trig_q <= 1'b0;
                    hold_q <= '0;
                    if (start_ok) begin
                        last_idx_q <= IDX_W'(len_cfg - CNT_W'(1));
                        nxt_idx_q  <= '0;
                        nxt_hold_q <= rd_hold;
                        nxt_pat_q  <= rd_pat;
                    end
                end
                ST_LAUNCH, ST_PLAY: begin
                    if (exit_now) begin
                        gate_q <= '0;
                        trig_q <= 1'b0;
                        hold_q <= '0;
                    end else if (load_evt) begin
                        gate_q     <= nxt_pat_q[GATE_W-1:0];
                        hold_q     <= (nxt_hold_q == '0) ? HOLD_W'(1) : nxt_hold_q;
                        trig_q     <= (state_q == ST_PLAY) && (nxt_idx_q == '0);
                        nxt_idx_q  <= succ_idx;
                        nxt_hold_q <= rd_hold;
                        nxt_pat_q  <= rd_pat;
                    end else begin
                        hold_q <= hold_q - 1'b1;
                        trig_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign gate_out = gate_q;
    assign trig_out = trig_q;
    assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/seq_player.sv
module seq_player
    import seq_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int LEN_W   = 8,
    parameter int ADDR_W  = $clog2(ENTRIES * ENTRY_STRIDE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [7:0]        tbl_wdata,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata,
    input  logic              run_start,
    input  logic              stop_req,
    output logic [4:0]        pins_out,
    output logic              busy
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [IDX_W-1:0]  rd_idx;
    logic [HOLD_W-1:0] rd_hold;
    logic [PAT_W-1:0]  rd_pat;
    logic [CNT_W-1:0]  len_q;
    logic [GATE_W-1:0] gate;
    logic              trig;

    seq_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_data (tbl_wdata),
        .rd_idx  (rd_idx),
        .rd_hold (rd_hold),
        .rd_pat  (rd_pat)
    );

    seq_len_reg #(.ENTRIES(ENTRIES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_we    (len_we),
        .len_wdata (len_wdata),
        .len_q     (len_q)
    );

    seq_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_start (run_start),
        .stop_req  (stop_req),
        .len_cfg   (len_q),
        .rd_hold   (rd_hold),
        .rd_pat    (rd_pat),
        .rd_idx    (rd_idx),
        .gate_out  (gate),
        .trig_out  (trig),
        .busy      (busy)
    );

    assign pins_out = {trig, gate};

endmodule

// File: rtl/seq_player_chk.sv
module seq_player_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_start,
    input logic       stop_req,
    input logic [4:0] pins_out,
    input logic       busy
);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pins_out == 5'd0));

    assert_stay_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !run_start) |=> !busy);

    assert_launch_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (pins_out == 5'd0));

    assert_exit_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(stop_req));

    assert_trig_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pins_out[4] |-> (busy && $past(busy)));

endmodule

bind seq_player seq_player_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .stop_req  (stop_req),
    .pins_out  (pins_out),
    .busy      (busy)
);

// File: tb/sim_seq_player.sv
`timescale 1ns/1ps
module sim_seq_player;

    localparam int ENTRIES = 16;
    localparam int AW      = $clog2(ENTRIES * 5 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_we = 1'b0;
    logic [AW-1:0] tbl_addr = '0;
    logic [7:0]    tbl_wdata = '0;
    logic          len_we = 1'b0;
    logic [7:0]    len_wdata = '0;
    logic          run_start = 1'b0;
    logic          stop_req = 1'b0;
    logic [4:0]    pins_out;
    logic          busy;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int tw [ENTRIES];
    int tp [ENTRIES];

    always #2 clk = ~clk;

    seq_player #(.ENTRIES(ENTRIES)) u0 (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .len_we(len_we), .len_wdata(len_wdata),
        .run_start(run_start), .stop_req(stop_req),
        .pins_out(pins_out), .busy(busy)
    );

    task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got busy/pins=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wr_byte(input int addr, input int data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = AW'(addr); tbl_wdata = 8'(data);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // R1: offsets 2 and 3 get junk that must not alter anything
    task automatic wr_entry(input int e, input int w, input int p);
        wr_byte(e*5 + 0, w & 8'hFF);
        wr_byte(e*5 + 1, (w >> 8) & 8'hFF);
        wr_byte(e*5 + 2, 8'hFF);
        wr_byte(e*5 + 3, 8'h5A);
        wr_byte(e*5 + 4, p);
        tw[e] = w; tp[e] = p;
    endtask

    task automatic wr_len(input int n);
        @(negedge clk);
        len_we = 1'b1; len_wdata = 8'(n);
        @(negedge clk);
        len_we = 1'b0;
    endtask

    // plays n entries for nper periods, stop held through the last one
    task automatic run_check(input int n, input int nper, input string tag);
        int plen;
        int k;
        logic [5:0] exp;
        plen = 0;
        for (int e = 0; e < n; e++) plen += (tw[e] == 0) ? 1 : tw[e];
        @(negedge clk);
        run_start = 1'b1;
        stop_req  = (nper == 1);
        @(posedge clk); @(negedge clk);
        run_start = 1'b0;
        chk({tag, " R3 launch"}, {busy, pins_out}, 6'b100000);
        for (int p = 0; p < nper; p++) begin
            k = 0;
            for (int e = 0; e < n; e++) begin
                int hold;
                hold = (tw[e] == 0) ? 1 : tw[e];
                for (int c = 0; c < hold; c++) begin
                    @(posedge clk); @(negedge clk);
                    exp = {1'b1, (p > 0 && e == 0 && c == 0), 4'(tp[e] & 4'hF)};
                    chk({tag, " R4 R5 R6 stream"}, {busy, pins_out}, exp);
                    k++;
                    // R8: start while busy ignored; R7: stop off the wrap ignored
                    run_start = (p == 0 && k == 1 && nper > 1);
                    stop_req  = (p == nper - 1) || (k == 1 && plen > 1);
                end
            end
        end
        @(posedge clk); @(negedge clk);
        run_start = 1'b0;
        chk({tag, " R7 R8 stop"}, {busy, pins_out}, 6'b000000);
        stop_req = 1'b0;
        repeat (2) @(negedge clk);
        chk({tag, " R3 R8 idle"}, {busy, pins_out}, 6'b000000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 reset", {busy, pins_out}, 6'b000000);
    endtask

    task automatic t_basic();
        wr_entry(0, 3, 8'hA9);
        wr_entry(1, 1, 8'h06);
        wr_entry(2, 0, 8'hF5);
        wr_entry(3, 2, 8'h3A);
        wr_byte(100, 8'h77); // R1: out of range
        wr_len(4);
        run_check(4, 3, "basic");
    endtask

    task automatic t_single();
        wr_entry(0, 2, 8'h01);
        wr_len(1);
        run_check(1, 2, "single");
    endtask

    task automatic t_zero_len();
        wr_len(0);
        @(negedge clk);
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 zero count", {busy, pins_out}, 6'b000000);
        end
    endtask

    task automatic t_saturate();
        for (int e = 0; e < ENTRIES; e++) wr_entry(e, e % 3, 8'h10 | (e & 15));
        wr_len(200);
        run_check(ENTRIES, 2, "R2 saturate");
    endtask

    task automatic t_high_byte();
        wr_byte(2*5 + 1, 8'h01);
        tw[2] = tw[2] | 256;
        wr_len(4);
        run_check(4, 1, "R1 high byte");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_single();
        t_zero_len();
        t_saturate();
        t_high_byte();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule